// File: doc/BRIEF.md
# Miss Entry Snoop Resolver

This block sits beside one outstanding-miss tracking entry of a cache. When a coherence snoop hits the entry's line, the block decides whether the snoop comes logically before or after the entry's own request. It then tells the cache what to do with the snoop and what to do with the entry's target queues. The queues and the copying of snoop data live outside the block. The block only produces commands for them: append the snoop as a snoop-sourced target, and rewrite pending upgrades into full exclusive reads in the primary queue, the deferred queue, or both.

A snoop is offered with a valid/ready handshake and is judged in the cycle it is accepted. The verdict outputs are combinational and are non-zero only in an accepted cycle. These outputs are the absorbed result and the marks to set on the snoop: cache-responding, responder-had-writable, satisfied and has-sharers. The block keeps two obligation flags, post-invalidate and post-downgrade. A snoop updates them on the following clock edge. Issuing the entry's request clears both flags. A snoop that arrives in the same cycle as the issue pulse is judged against the entry state from before the issue.

Top module: `snoop_order_resolver`

## Requirements
- R1: While rst_n is low at a clock edge, both obligation flags and snp_ready read 0 after that edge. After the first edge with rst_n high, snp_ready reads 1 and the flags stay 0.
- R2: In a cycle with no accepted snoop (snp_valid or snp_ready low), every verdict and queue-command output is 0 and neither flag changes.
- R3: The snoop precedes the entry when the entry is not in service, or when the snoop is express and downstream-pending is set. In that case the snoop is not absorbed. Both rewrite commands are 1 exactly when the snoop needs writable or is a cache-invalidate. No other output is raised and neither flag changes.
- R4: A snoop that follows the entry (any other accepted snoop) never rewrites the primary queue. It rewrites the deferred queue exactly when it needs writable or is a cache-invalidate.
- R5: A following snoop seen while post-invalidate is set, or while the head primary target is a cache-invalidate, is absorbed and raises no append, no mark and no flag change.
- R6: Otherwise a following snoop is appended to the primary queue exactly when the entry is pending-modified or the snoop is an invalidate. The append's pending mark is 1 only when downstream-pending and primary-needs-writable are both 1.
- R7: Cache-responding and responder-had-writable are both raised exactly when the snoop is appended, the entry is pending-modified, the snoop needs a response and the snoop is not clean.
- R8: An appended snoop that needs writable or is an invalidate sets post-invalidate at the next edge.
- R9: An appended clean snoop seen while pending-modified is marked satisfied.
- R10: A following snoop not stopped by R5 that neither needs writable nor is uncacheable raises has-sharers and sets post-downgrade at the next edge.
- R11: An ent_issue pulse clears both flags at the next edge. A snoop in that same cycle is judged with ent_in_service low.
- R12: Every accepted following snoop reports absorbed = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| snp_valid | input | 1 | Snoop offered |
| snp_ready | output | 1 | Snoop can be accepted |
| snp_need_wr | input | 1 | Snoop needs a writable copy |
| snp_inval | input | 1 | Snoop is an invalidate |
| snp_cache_inv | input | 1 | Snoop is a cache-invalidate maintenance request |
| snp_clean | input | 1 | Snoop is a clean request |
| snp_need_resp | input | 1 | Snoop expects a response |
| snp_uncache | input | 1 | Snoop is uncacheable |
| snp_express | input | 1 | Snoop is an express snoop |
| ent_in_service | input | 1 | Entry's request has been issued |
| ent_dn_pending | input | 1 | Entry's request is buffered downstream |
| ent_pend_mod | input | 1 | Entry awaits a writable copy |
| ent_head_cinv | input | 1 | Head primary target is a cache-invalidate |
| ent_pri_need_wr | input | 1 | Primary queue needs writable |
| ent_issue | input | 1 | Mark-in-service pulse |
| res_absorbed | output | 1 | Snoop absorbed by the entry |
| mk_cache_resp | output | 1 | Mark snoop cache-responding |
| mk_had_wr | output | 1 | Mark responder had writable |
| mk_satisfied | output | 1 | Mark snoop satisfied |
| mk_has_sharers | output | 1 | Mark snoop has sharers |
| q_append | output | 1 | Append snoop target to primary queue |
| q_append_pend | output | 1 | Pending mark for appended target |
| q_rw_primary | output | 1 | Rewrite upgrades in primary queue |
| q_rw_deferred | output | 1 | Rewrite upgrades in deferred queue |
| post_inv | output | 1 | Post-invalidate obligation flag |
| post_dgr | output | 1 | Post-downgrade obligation flag |

## Verification
Random snoops with random attribute bits are mixed with random entry state. Not-in-service cycles, express snoops with downstream-pending set, and in-service cycles fall on both sides of the ordering split, so a wrong split shows as a wrong absorbed bit or a wrong primary rewrite. The post-invalidate flag builds up and is cleared by random issue pulses. This separates the early-stop case from the append case, which differ only in whether marks and flags move. Directed cases add a responding snoop after post-invalidate is already set, a clean snoop while pending-modified, and a snoop that coincides with an issue pulse.

// File: rtl/sor_pkg.sv
// Shared types for the snoop order resolver.
// Assumes: one snoop judged per accepted cycle.
package sor_pkg;

    // Attributes carried by an incoming snoop.
    typedef struct packed {
        logic need_wr;
        logic inval;
        logic cache_inv;
        logic clean;
        logic need_resp;
        logic uncache;
        logic express;
    } sor_snoop_t;

    // Entry state visible to the resolver.
    typedef struct packed {
        logic in_service;
        logic dn_pending;
        logic pend_mod;
        logic head_cinv;
        logic pri_need_wr;
    } sor_entry_t;

    // Full verdict for one snoop.
    typedef struct packed {
        logic absorbed;
        logic cache_resp;
        logic had_wr;
        logic satisfied;
        logic has_sharers;
        logic append;
        logic append_pend;
        logic rw_pri;
        logic rw_def;
        logic set_pinv;
        logic set_pdgr;
    } sor_verdict_t;

endpackage

// File: rtl/sor_order_gate.sv
// Order gate: decides whether an accepted snoop comes after the entry's
// own request (follows) or before it. Assumes entry state reflects the
// cycle before any same-cycle issue pulse.
module sor_order_gate
    import sor_pkg::*;
(
    input  logic       fire,
    input  sor_snoop_t snp,
    input  sor_entry_t ent,
    output logic       follows,
    output logic       precedes,
    output logic       inv_any
);

    // Classify ordering and the invalidating nature of the snoop.
    always_comb begin
        inv_any  = snp.need_wr | snp.cache_inv;
        follows  = fire & ent.in_service & ~(snp.express & ent.dn_pending);
        precedes = fire & ~follows;
    end

endmodule

// File: rtl/sor_verdict.sv
// Verdict logic: given the ordering class and the current obligation
// flags, produces the snoop marks, queue commands and flag set requests.
// Assumes follows and precedes are never both high.
module sor_verdict
    import sor_pkg::*;
(
    input  logic         follows,
    input  logic         precedes,
    input  logic         inv_any,
    input  sor_snoop_t   snp,
    input  sor_entry_t   ent,
    input  logic         pinv_q,
    output sor_verdict_t vd
);

    logic live;
    logic appends;

    // Decide whether the snoop survives the early stop and is queued.
    always_comb begin
        live    = follows & ~(pinv_q | ent.head_cinv);
        appends = live & (ent.pend_mod | snp.inval);
    end

    // Assemble the verdict fields.
    always_comb begin
        vd             = '0;
        vd.absorbed    = follows;
        vd.rw_pri      = precedes & inv_any;
        vd.rw_def      = (precedes | follows) & inv_any;
        vd.append      = appends;
        vd.append_pend = appends & ent.dn_pending & ent.pri_need_wr;
        vd.cache_resp  = appends & ent.pend_mod & snp.need_resp & ~snp.clean;
        vd.had_wr      = appends & ent.pend_mod & snp.need_resp & ~snp.clean;
        vd.satisfied   = appends & ent.pend_mod & snp.clean;
        vd.set_pinv    = appends & (snp.need_wr | snp.inval);
        vd.has_sharers = live & ~snp.need_wr & ~snp.uncache;
        vd.set_pdgr    = live & ~snp.need_wr & ~snp.uncache;
    end

endmodule

// File: rtl/sor_flag_regs.sv
// Obligation flag registers plus the acceptance ready register.
// Issue clears both flags and wins over any set request.
module sor_flag_regs (
    input  logic clk,
    input  logic rst_n,
    input  logic issue,
    input  logic set_pinv,
    input  logic set_pdgr,
    output logic pinv_q,
    output logic pdgr_q,
    output logic ready_q
);

    // Hold the post-invalidate and post-downgrade obligations.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pinv_q <= 1'b0;
            pdgr_q <= 1'b0;
        end else if (issue) begin
            pinv_q <= 1'b0;
            pdgr_q <= 1'b0;
        end else begin
            pinv_q <= pinv_q | set_pinv;
            pdgr_q <= pdgr_q | set_pdgr;
        end
    end

    // Open the snoop port one edge after reset release.
    always_ff @(posedge clk) begin
        if (!rst_n) ready_q <= 1'b0;
        else        ready_q <= 1'b1;
    end

endmodule

// File: rtl/snoop_order_resolver.sv
// Top: judges snoops against one miss entry, emitting snoop marks and
// queue commands combinationally in the accepted cycle and updating the
// obligation flags on the next edge.
module snoop_order_resolver
    import sor_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic snp_valid,
    output logic snp_ready,
    input  logic snp_need_wr,
    input  logic snp_inval,
    input  logic snp_cache_inv,
    input  logic snp_clean,
    input  logic snp_need_resp,
    input  logic snp_uncache,
    input  logic snp_express,
    input  logic ent_in_service,
    input  logic ent_dn_pending,
    input  logic ent_pend_mod,
    input  logic ent_head_cinv,
    input  logic ent_pri_need_wr,
    input  logic ent_issue,
    output logic res_absorbed,
    output logic mk_cache_resp,
    output logic mk_had_wr,
    output logic mk_satisfied,
    output logic mk_has_sharers,
    output logic q_append,
    output logic q_append_pend,
    output logic q_rw_primary,
    output logic q_rw_deferred,
    output logic post_inv,
    output logic post_dgr
);

    sor_snoop_t   snp;
    sor_entry_t   ent;
    sor_verdict_t vd;
    logic         fire, follows, precedes, inv_any;
    logic         pinv_q, pdgr_q, ready_q;

    // Pack port bits into the shared structures.
    always_comb begin
        snp.need_wr     = snp_need_wr;
        snp.inval       = snp_inval;
        snp.cache_inv   = snp_cache_inv;
        snp.clean       = snp_clean;
        snp.need_resp   = snp_need_resp;
        snp.uncache     = snp_uncache;
        snp.express     = snp_express;
        ent.in_service  = ent_in_service;
        ent.dn_pending  = ent_dn_pending;
        ent.pend_mod    = ent_pend_mod;
        ent.head_cinv   = ent_head_cinv;
        ent.pri_need_wr = ent_pri_need_wr;
        fire            = snp_valid & ready_q;
    end

    sor_order_gate u_gate (
        .fire     (fire),
        .snp      (snp),
        .ent      (ent),
        .follows  (follows),
        .precedes (precedes),
        .inv_any  (inv_any)
    );

    sor_verdict u_verdict (
        .follows  (follows),
        .precedes (precedes),
        .inv_any  (inv_any),
        .snp      (snp),
        .ent      (ent),
        .pinv_q   (pinv_q),
        .vd       (vd)
    );

    sor_flag_regs u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .issue    (ent_issue),
        .set_pinv (vd.set_pinv),
        .set_pdgr (vd.set_pdgr),
        .pinv_q   (pinv_q),
        .pdgr_q   (pdgr_q),
        .ready_q  (ready_q)
    );

    // Drive the output ports from the verdict and registers.
    always_comb begin
        snp_ready      = ready_q;
        res_absorbed   = vd.absorbed;
        mk_cache_resp  = vd.cache_resp;
        mk_had_wr      = vd.had_wr;
        mk_satisfied   = vd.satisfied;
        mk_has_sharers = vd.has_sharers;
        q_append       = vd.append;
        q_append_pend  = vd.append_pend;
        q_rw_primary   = vd.rw_pri;
        q_rw_deferred  = vd.rw_def;
        post_inv       = pinv_q;
        post_dgr       = pdgr_q;
    end

endmodule

// File: rtl/snoop_order_resolver_chk.sv
// Checker for snoop_order_resolver, attached by bind.
module snoop_order_resolver_chk (
    input logic clk,
    input logic rst_n,
    input logic snp_valid,
    input logic snp_ready,
    input logic snp_need_wr,
    input logic snp_inval,
    input logic snp_express,
    input logic ent_in_service,
    input logic ent_dn_pending,
    input logic ent_pend_mod,
    input logic ent_head_cinv,
    input logic ent_issue,
    input logic res_absorbed,
    input logic mk_cache_resp,
    input logic mk_had_wr,
    input logic mk_satisfied,
    input logic mk_has_sharers,
    input logic q_append,
    input logic q_rw_primary,
    input logic post_inv,
    input logic post_dgr
);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (!post_inv && !post_dgr && !snp_ready));

    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(snp_valid && snp_ready) |-> !(res_absorbed || q_append || mk_has_sharers || q_rw_primary));

    // R3
    precede_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_valid && snp_ready && !ent_in_service) |-> (!res_absorbed && !q_append && !mk_has_sharers));

    // R4
    follow_no_pri_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_absorbed |-> !q_rw_primary);

    // R5
    early_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_absorbed && (post_inv || ent_head_cinv)) |-> (!q_append && !mk_has_sharers && !mk_satisfied));

    // R7
    respond_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mk_cache_resp |-> (mk_had_wr && q_append && ent_pend_mod));

    // R8
    pinv_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q_append && (snp_need_wr || snp_inval) && !ent_issue) |=> post_inv);

    // R9
    sat_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mk_satisfied |-> !mk_cache_resp);

    // R11
    issue_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ent_issue |=> (!post_inv && !post_dgr));

    // R12
    express_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_valid && snp_ready && ent_in_service && !(snp_express && ent_dn_pending)) |-> res_absorbed);

endmodule

bind snoop_order_resolver snoop_order_resolver_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .snp_valid      (snp_valid),
    .snp_ready      (snp_ready),
    .snp_need_wr    (snp_need_wr),
    .snp_inval      (snp_inval),
    .snp_express    (snp_express),
    .ent_in_service (ent_in_service),
    .ent_dn_pending (ent_dn_pending),
    .ent_pend_mod   (ent_pend_mod),
    .ent_head_cinv  (ent_head_cinv),
    .ent_issue      (ent_issue),
    .res_absorbed   (res_absorbed),
    .mk_cache_resp  (mk_cache_resp),
    .mk_had_wr      (mk_had_wr),
    .mk_satisfied   (mk_satisfied),
    .mk_has_sharers (mk_has_sharers),
    .q_append       (q_append),
    .q_rw_primary   (q_rw_primary),
    .post_inv       (post_inv),
    .post_dgr       (post_dgr)
);

// File: tb/tb_snoop_order_resolver.sv
module tb_snoop_order_resolver;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic snp_valid = 0, snp_need_wr = 0, snp_inval = 0, snp_cache_inv = 0;
    logic snp_clean = 0, snp_need_resp = 0, snp_uncache = 0, snp_express = 0;
    logic ent_in_service = 0, ent_dn_pending = 0, ent_pend_mod = 0;
    logic ent_head_cinv = 0, ent_pri_need_wr = 0, ent_issue = 0;
    logic snp_ready, res_absorbed, mk_cache_resp, mk_had_wr, mk_satisfied;
    logic mk_has_sharers, q_append, q_append_pend, q_rw_primary, q_rw_deferred;
    logic post_inv, post_dgr;

    int n_chk = 0;
    int n_bad = 0;
    logic m_pinv = 0, m_pdgr = 0;

    // expected outputs, order: absorbed,resp,hadwr,sat,sharers,app,apppend,rwp,rwd
    logic [8:0] exp_v;
    logic       exp_spinv, exp_spdgr;

    always #10 clk = ~clk;

    snoop_order_resolver dut (.*);

    task automatic check(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%b exp=%b at %0t", tag, act, exp, $time);
        end
    endtask

    // Reference model from the requirement list.
    task automatic model(input logic fire);
        logic fol, pre, inv_any, live, app, rsp;
        inv_any = snp_need_wr | snp_cache_inv;
        fol  = fire && ent_in_service && !(snp_express && ent_dn_pending);
        pre  = fire && !fol;
        live = fol && !m_pinv && !ent_head_cinv;
        app  = live && (ent_pend_mod || snp_inval);
        rsp  = app && ent_pend_mod && snp_need_resp && !snp_clean;
        exp_v = {fol, rsp, rsp, app && ent_pend_mod && snp_clean,
                 live && !snp_need_wr && !snp_uncache, app,
                 app && ent_dn_pending && ent_pri_need_wr,
                 pre && inv_any, (pre || fol) && inv_any};
        exp_spinv = app && (snp_need_wr || snp_inval);
        exp_spdgr = live && !snp_need_wr && !snp_uncache;
    endtask

    // Compare combinational outputs, then advance the model past the edge.
    task automatic step_check();
        #5;
        model(snp_valid && snp_ready);
        check("R12/R3 absorbed", res_absorbed,   exp_v[8]);
        check("R7 cache_resp",   mk_cache_resp,  exp_v[7]);
        check("R7 had_wr",       mk_had_wr,      exp_v[6]);
        check("R9 satisfied",    mk_satisfied,   exp_v[5]);
        check("R10 has_sharers", mk_has_sharers, exp_v[4]);
        check("R6 append",       q_append,       exp_v[3]);
        check("R6 append_pend",  q_append_pend,  exp_v[2]);
        check("R3 rw_primary",   q_rw_primary,   exp_v[1]);
        check("R4 rw_deferred",  q_rw_deferred,  exp_v[0]);
        @(posedge clk);
        if (ent_issue) begin
            m_pinv = 0; m_pdgr = 0;
        end else begin
            m_pinv = m_pinv | exp_spinv;
            m_pdgr = m_pdgr | exp_spdgr;
        end
        @(negedge clk);
        check("R8 post_inv",  post_inv, m_pinv);
        check("R10 post_dgr", post_dgr, m_pdgr);
    endtask

    task automatic drive(input logic [6:0] s, input logic [4:0] e, input logic v, input logic iss);
        {snp_need_wr, snp_inval, snp_cache_inv, snp_clean, snp_need_resp, snp_uncache, snp_express} = s;
        {ent_in_service, ent_dn_pending, ent_pend_mod, ent_head_cinv, ent_pri_need_wr} = e;
        snp_valid = v;
        ent_issue = iss;
    endtask

    initial begin
        #4_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        check("R1 post_inv reset", post_inv, 1'b0);
        check("R1 post_dgr reset", post_dgr, 1'b0);
        check("R1 ready in reset", snp_ready, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 ready after reset", snp_ready, 1'b1);
        check("R1 flags after reset", post_inv | post_dgr, 1'b0);

        // R2: offered-nothing cycle with all attributes high
        drive(7'h7f, 5'h1f, 1'b0, 1'b0);
        step_check();

        // R8/R7: in-service, pending-modified responding write snoop
        drive(7'b1000100, 5'b10100, 1'b1, 1'b0);
        step_check();
        // R5: post_inv now set; responding snoop is absorbed without marks
        drive(7'b0100100, 5'b10100, 1'b1, 1'b0);
        step_check();
        check("R5 no append after post_inv", q_append, 1'b0);

        // R11: issue pulse with coincident snoop that precedes
        drive(7'b1000000, 5'b00000, 1'b1, 1'b1);
        step_check();
        check("R11 flags cleared", post_inv | post_dgr, 1'b0);

        // R9: clean snoop while pending-modified
        drive(7'b0001100, 5'b10100, 1'b1, 1'b0);
        step_check();
        // R3: express with downstream pending precedes
        drive(7'b0010001, 5'b11000, 1'b1, 1'b0);
        step_check();
        // R5: head cache-invalidate stops further action
        drive(7'b0100000, 5'b10110, 1'b1, 1'b0);
        step_check();
        // R6: append pending mark
        drive(7'b0100000, 5'b11101, 1'b1, 1'b0);
        step_check();

        for (int i = 0; i < 3000; i++) begin
            logic [4:0] e;
            logic       iss;
            e   = 5'($urandom);
            iss = ($urandom % 8 == 0) && !e[4];
            drive(7'($urandom), e, ($urandom % 4) != 0, iss);
            step_check();
        end

        drive(7'h0, 5'h0, 1'b0, 1'b0);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule